// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that finishes every instruction in one clock period. In each period it fetches a word from an external instruction port and decodes it. It then reads two general registers, runs the ALU, and drives a data-memory port for loads and stores. It also chooses the next program counter. The program counter, the register file and the data-memory write all update on the same rising edge. Both memory ports are external. Instruction and load data are expected combinationally within the same period. A store is written at the closing edge.

The core executes register-register ALU operations and register-immediate ALU operations. It also executes word load, word store, branch-if-equal and branch-if-not-equal. Multiplexers steer the datapath in three places: which field names the destination register, whether ALU operand B is a register or the sign-extended immediate, and whether the ALU result or the load data is written back. A data address whose two low bits are not zero makes the core drop the memory access and raise a sticky error flag.

Instruction layout: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, function code in 5:0, and the 16-bit immediate or displacement in 15:0.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, and after it is released until the first instruction retires, the PC reads 0, every register reads 0 and align_err_o is 0.
- R2: An instruction that does not take a branch advances the PC by 4 at the rising edge.
- R3: Opcode 0x00 selects a register-register operation that writes rd with rs OP rt. The function codes are 0x20 add, 0x22 subtract (rs-rt), 0x24 and, 0x25 or, 0x26 xor, and 0x2A signed set-less-than (result 1 or 0).
- R4: Opcodes 0x08 add, 0x0C and, 0x0D or and 0x0E xor write rt with rs OP sign-extended imm16.
- R5: Register 0 always reads as zero, and writing it has no effect.
- R6: Opcode 0x23 loads into rt the data word at address rs + sign-extended imm16.
- R7: Opcode 0x2B stores the value of rt to address rs + sign-extended imm16. No other instruction writes data memory.
- R8: Opcode 0x04 (equal) and opcode 0x05 (not equal) compare rs with rt. When the condition holds, the next PC is PC + 4 + (sign-extended imm16 << 2). Otherwise it is PC + 4.
- R9: A load or store whose address has nonzero bits 1:0 performs no memory access and writes no register. It sets align_err_o, which stays set until reset.
- R10: An opcode, or a register-register function code, outside those listed leaves registers and memory unchanged and advances the PC by 4.
- R11: A register written by one instruction holds the new value when the next instruction reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 32 | Byte address of the current instruction (PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data byte address for load or store |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, written at the rising edge |
| dmem_re_o | output | 1 | Load strobe |
| dmem_rdata_i | input | 32 | Load data for dmem_addr_o |
| align_err_o | output | 1 | Sticky misaligned data access flag |

## Verification
Each instruction's register result, memory write and next PC become visible one rising edge after that instruction appears on the fetch port. A load's data is used in the same period it is addressed. The bench drives and samples on falling edges only. It holds reset while it loads a program, and reads results only after the program has reached its final self-branch. Register values are brought out by store instructions and compared in the bench's data array, against values the bench computes from the instruction semantics.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;    // 1: rd field, 0: rt field
    logic    b_imm;     // 1: operand B is immediate
    logic    wb_mem;    // 1: write back load data
    logic    mem_rd;
    logic    mem_wr;
    logic    br_eq;
    logic    br_ne;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [31:0] instr_i,
  output ctrl_t       ctrl_o,
  output logic [4:0]  rs_o,
  output logic [4:0]  rt_o,
  output logic [4:0]  rd_o,
  output logic [15:0] imm_o
);
  logic [5:0] op, fn;

  assign op    = instr_i[31:26];
  assign fn    = instr_i[5:0];
  assign rs_o  = instr_i[25:21];
  assign rt_o  = instr_i[20:16];
  assign rd_o  = instr_i[15:11];
  assign imm_o = instr_i[15:0];

  always_comb begin
    ctrl_o = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (op)
      OP_RR: begin
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.reg_we = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_XOR:  ctrl_o.alu_op = ALU_XOR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI, OP_ANDI, OP_ORI, OP_XORI: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.alu_op = (op == OP_ANDI) ? ALU_AND :
                        (op == OP_ORI)  ? ALU_OR  :
                        (op == OP_XORI) ? ALU_XOR : ALU_ADD;
      end
      OP_LW: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.mem_rd = 1'b1;
      end
      OP_SW: begin
        ctrl_o.b_imm  = 1'b1;
        ctrl_o.mem_wr = 1'b1;
      end
      OP_BEQ:  ctrl_o.br_eq = 1'b1;
      OP_BNE:  ctrl_o.br_ne = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  output logic [W-1:0]  ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [W-1:0]  rb_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] w_addr_i,
  input  logic [W-1:0]  w_data_i
);
  // entry 0 has no storage; it reads as zero
  logic [W-1:0] regs [1:N-1];

  for (genvar g = 1; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs[g] <= '0;
      else if (we_i && w_addr_i == AW'(g))        regs[g] <= w_data_i;
    end
  end

  always_comb begin
    ra_data_o = '0;
    rb_data_o = '0;
    for (int k = 1; k < N; k++) begin
      if (ra_addr_i == AW'(k)) ra_data_o = regs[k];
      if (rb_addr_i == AW'(k)) rb_data_o = regs[k];
    end
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int NREG = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [31:0]  imem_addr_o,
  input  logic [31:0]  imem_data_i,
  output logic [31:0]  dmem_addr_o,
  output logic [31:0]  dmem_wdata_o,
  output logic         dmem_we_o,
  output logic         dmem_re_o,
  input  logic [31:0]  dmem_rdata_i,
  output logic         align_err_o
);
  localparam int RAW = $clog2(NREG);
  localparam int IMW = 16;

  ctrl_t          ctrl;
  logic [4:0]     rs, rt, rd;
  logic [IMW-1:0] imm16;
  logic [W-1:0]   imm_ext, rs_val, rt_val, opb, alu_y, wb_data;
  logic [W-1:0]   pc_q, pc_d, pc_inc, pc_br;
  logic [RAW-1:0] w_addr;
  logic           misalign, reg_we, take_br, err_q;

  sc_decode u_dec (
    .instr_i (imem_data_i),
    .ctrl_o  (ctrl),
    .rs_o    (rs),
    .rt_o    (rt),
    .rd_o    (rd),
    .imm_o   (imm16)
  );

  assign imm_ext = {{(W-IMW){imm16[IMW-1]}}, imm16};

  sc_regfile #(.W(W), .N(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ra_addr_i (RAW'(rs)),
    .ra_data_o (rs_val),
    .rb_addr_i (RAW'(rt)),
    .rb_data_o (rt_val),
    .we_i      (reg_we),
    .w_addr_i  (w_addr),
    .w_data_i  (wb_data)
  );

  assign opb = ctrl.b_imm ? imm_ext : rt_val;

  sc_alu #(.W(W)) u_alu (
    .a_i  (rs_val),
    .b_i  (opb),
    .op_i (ctrl.alu_op),
    .y_o  (alu_y)
  );

  // data side
  assign misalign     = (ctrl.mem_rd | ctrl.mem_wr) & (|alu_y[1:0]);
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = rst_ni & ctrl.mem_wr & ~misalign;
  assign dmem_re_o    = rst_ni & ctrl.mem_rd & ~misalign;

  // write-back
  assign wb_data = ctrl.wb_mem ? dmem_rdata_i : alu_y;
  assign w_addr  = ctrl.dst_rd ? RAW'(rd) : RAW'(rt);
  assign reg_we  = ctrl.reg_we & ~(ctrl.mem_rd & misalign);

  // next PC
  assign pc_inc  = pc_q + W'(4);
  assign pc_br   = pc_inc + {imm_ext[W-3:0], 2'b00};
  assign take_br = (ctrl.br_eq & (rs_val == rt_val)) |
                   (ctrl.br_ne & (rs_val != rt_val));
  assign pc_d    = take_br ? pc_br : pc_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      err_q <= err_q | misalign;
    end
  end

  assign imem_addr_o = pc_q;
  assign align_err_o = err_q;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] imem_addr_o,
  input logic [31:0] imem_data_i,
  input logic [31:0] dmem_addr_o,
  input logic        dmem_we_o,
  input logic        dmem_re_o,
  input logic        align_err_o
);
  logic [5:0] op;
  logic       known;
  assign op    = imem_data_i[31:26];
  assign known = op inside {OP_RR, OP_BEQ, OP_BNE, OP_ADDI, OP_ANDI,
                            OP_ORI, OP_XORI, OP_LW, OP_SW};

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (imem_addr_o == 32'd0 && !align_err_o);
    end
  end

  a_r2_rr_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RR) |=> imem_addr_o == $past(imem_addr_o) + 32'd4);

  a_r7_store_only_sw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> op == OP_SW);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> align_err_o);

  a_r9_aligned_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_o || dmem_re_o) |-> dmem_addr_o[1:0] == 2'b00);

  a_r10_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |-> (!dmem_we_o && !dmem_re_o));

  a_r10_unknown_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known |=> imem_addr_o == $past(imem_addr_o) + 32'd4);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .imem_addr_o (imem_addr_o),
  .imem_data_i (imem_data_i),
  .dmem_addr_o (dmem_addr_o),
  .dmem_we_o   (dmem_we_o),
  .dmem_re_o   (dmem_re_o),
  .align_err_o (align_err_o)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re, align_err;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int checks = 0, errors = 0, pw = 0, cyc = 0;

  always #10 clk = ~clk;   // 50 MHz

  sc_core uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata),
    .dmem_we_o(dmem_we), .dmem_re_o(dmem_re),
    .dmem_rdata_i(dmem_rdata), .align_err_o(align_err)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] rr(logic [5:0] fn, logic [4:0] d, logic [4:0] s, logic [4:0] t);
    return {6'h00, s, t, d, 5'h00, fn};
  endfunction
  function automatic logic [31:0] ri(logic [5:0] op, logic [4:0] t, logic [4:0] s, logic [15:0] imm);
    return {op, s, t, imm};
  endfunction
  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(logic [31:0] w);
    imem[pw] = w;
    pw++;
  endtask

  // hold reset, clear program, preset data
  task automatic begin_prog();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem[i] = HALT;
      dmem[i] = 32'hD000_0000 | i;
    end
    pw = 0;
  endtask

  task automatic run_prog(int n);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    begin_prog();
    put(ri(6'h2B, 5'd1, 5'd0, 16'd0));
    put(ri(6'h2B, 5'd2, 5'd0, 16'd4));
    put(ri(6'h2B, 5'd31, 5'd0, 16'd8));
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'd0);
    chk("R1 err in reset", {31'd0, align_err}, 32'd0);
    run_prog(20);
    chk("R1 r1 cleared", dmem[0], 32'd0);
    chk("R1 r2 cleared", dmem[1], 32'd0);
    chk("R1 r31 cleared", dmem[2], 32'd0);
    chk("R2 pc parked at halt", imem_addr, 32'd12);
  endtask

  task automatic t_alu_rr();
    logic [31:0] a, b;
    a = 32'hFFFF_FFF9; b = 32'd100;
    begin_prog();
    put(ri(6'h08, 5'd1, 5'd0, 16'hFFF9));
    put(ri(6'h08, 5'd2, 5'd0, 16'd100));
    put(rr(6'h20, 5'd3, 5'd1, 5'd2));
    put(rr(6'h22, 5'd4, 5'd1, 5'd2));
    put(rr(6'h24, 5'd5, 5'd1, 5'd2));
    put(rr(6'h25, 5'd6, 5'd1, 5'd2));
    put(rr(6'h26, 5'd7, 5'd1, 5'd2));
    put(rr(6'h2A, 5'd8, 5'd1, 5'd2));
    put(rr(6'h2A, 5'd9, 5'd2, 5'd1));
    for (int r = 3; r <= 9; r++) put(ri(6'h2B, 5'(r), 5'd0, 16'((r - 3) * 4)));
    run_prog(40);
    chk("R3 R11 add", dmem[0], a + b);
    chk("R3 sub", dmem[1], a - b);
    chk("R3 and", dmem[2], a & b);
    chk("R3 or", dmem[3], a | b);
    chk("R3 xor", dmem[4], a ^ b);
    chk("R3 slt true", dmem[5], 32'd1);
    chk("R3 slt false", dmem[6], 32'd0);
  endtask

  task automatic t_alu_imm();
    begin_prog();
    put(ri(6'h08, 5'd1, 5'd0, 16'h7FFF));
    put(ri(6'h0D, 5'd2, 5'd1, 16'hFFFF));
    put(ri(6'h0C, 5'd3, 5'd1, 16'h8000));
    put(ri(6'h0E, 5'd4, 5'd1, 16'h00F0));
    put(ri(6'h08, 5'd5, 5'd1, 16'h8000));
    for (int r = 1; r <= 5; r++) put(ri(6'h2B, 5'(r), 5'd0, 16'((r - 1) * 4)));
    run_prog(30);
    chk("R4 addi", dmem[0], 32'h0000_7FFF);
    chk("R4 ori sign-ext", dmem[1], 32'hFFFF_FFFF);
    chk("R4 andi sign-ext", dmem[2], 32'h0000_0000);
    chk("R4 xori", dmem[3], 32'h0000_7F0F);
    chk("R4 addi negative", dmem[4], 32'hFFFF_FFFF);
  endtask

  task automatic t_zero_reg();
    begin_prog();
    put(ri(6'h08, 5'd0, 5'd0, 16'd55));
    put(rr(6'h20, 5'd0, 5'd0, 5'd0));
    put(rr(6'h20, 5'd1, 5'd0, 5'd0));
    put(ri(6'h2B, 5'd0, 5'd0, 16'd0));
    put(ri(6'h2B, 5'd1, 5'd0, 16'd4));
    run_prog(20);
    chk("R5 r0 stored", dmem[0], 32'd0);
    chk("R5 r0+r0", dmem[1], 32'd0);
  endtask

  task automatic t_ldst();
    begin_prog();
    dmem[10] = 32'h1234_5678;
    dmem[12] = 32'hCAFE_F00D;
    put(ri(6'h08, 5'd1, 5'd0, 16'd48));
    put(ri(6'h23, 5'd2, 5'd1, 16'hFFF8));
    put(ri(6'h2B, 5'd2, 5'd1, 16'd12));
    put(ri(6'h23, 5'd3, 5'd1, 16'd0));
    put(ri(6'h2B, 5'd3, 5'd1, 16'hFFD0));
    put(rr(6'h20, 5'd4, 5'd2, 5'd3));
    put(ri(6'h2B, 5'd4, 5'd0, 16'd4));
    run_prog(25);
    chk("R6 R7 load neg disp, store", dmem[15], 32'h1234_5678);
    chk("R6 R7 load, store neg disp", dmem[0], 32'hCAFE_F00D);
    chk("R6 R11 load then use", dmem[1], 32'h1234_5678 + 32'hCAFE_F00D);
    chk("R7 untouched word", dmem[20], 32'hD000_0014);
  endtask

  task automatic t_branch();
    begin_prog();
    put(ri(6'h08, 5'd1, 5'd0, 16'd5));
    put(ri(6'h08, 5'd2, 5'd0, 16'd5));
    put(ri(6'h04, 5'd2, 5'd1, 16'd2));    // taken, skip two
    put(ri(6'h08, 5'd3, 5'd0, 16'd1));
    put(ri(6'h08, 5'd3, 5'd0, 16'd2));
    put(ri(6'h05, 5'd2, 5'd1, 16'd1));    // not taken
    put(ri(6'h08, 5'd4, 5'd0, 16'd9));
    put(ri(6'h08, 5'd5, 5'd0, 16'd3));
    put(ri(6'h05, 5'd1, 5'd5, 16'd1));    // taken, skip one
    put(ri(6'h08, 5'd6, 5'd0, 16'd7));
    put(ri(6'h04, 5'd1, 5'd5, 16'd1));    // not taken
    put(ri(6'h08, 5'd9, 5'd0, 16'd4));
    put(ri(6'h08, 5'd7, 5'd0, 16'd3));
    put(ri(6'h08, 5'd8, 5'd8, 16'd2));    // loop body
    put(ri(6'h08, 5'd7, 5'd7, 16'hFFFF));
    put(ri(6'h05, 5'd0, 5'd7, 16'hFFFD)); // backward
    put(ri(6'h2B, 5'd3, 5'd0, 16'd0));
    put(ri(6'h2B, 5'd4, 5'd0, 16'd4));
    put(ri(6'h2B, 5'd6, 5'd0, 16'd8));
    put(ri(6'h2B, 5'd8, 5'd0, 16'd12));
    put(ri(6'h2B, 5'd9, 5'd0, 16'd16));
    run_prog(60);
    chk("R8 beq taken skips", dmem[0], 32'd0);
    chk("R8 bne not taken falls through", dmem[1], 32'd9);
    chk("R8 bne taken skips", dmem[2], 32'd0);
    chk("R8 backward loop count", dmem[3], 32'd6);
    chk("R8 beq not taken", dmem[4], 32'd4);
    chk("R2 halt pc", imem_addr, 32'd84);
  endtask

  task automatic t_unknown();
    begin_prog();
    put(ri(6'h08, 5'd1, 5'd0, 16'd4));
    put(ri(6'h3F, 5'd1, 5'd0, 16'd99));
    put(rr(6'h3F, 5'd1, 5'd0, 5'd0));
    put({6'h3E, 5'd0, 5'd1, 16'd0});
    put(ri(6'h2B, 5'd1, 5'd0, 16'd4));
    run_prog(20);
    chk("R10 reg unchanged", dmem[1], 32'd4);
    chk("R10 memory unchanged", dmem[0], 32'hD000_0000);
    chk("R10 pc advanced", imem_addr, 32'd20);
  endtask

  task automatic t_misalign();
    begin_prog();
    dmem[1] = 32'hAAAA_5555;
    put(ri(6'h08, 5'd1, 5'd0, 16'd6));
    put(ri(6'h08, 5'd2, 5'd0, 16'd77));
    put(ri(6'h08, 5'd3, 5'd0, 16'd33));
    put(ri(6'h2B, 5'd2, 5'd1, 16'd0));    // addr 6
    put(ri(6'h23, 5'd3, 5'd1, 16'd1));    // addr 7
    put(ri(6'h2B, 5'd3, 5'd0, 16'd8));
    run_prog(20);
    chk("R9 store suppressed", dmem[1], 32'hAAAA_5555);
    chk("R9 load writes no reg", dmem[2], 32'd33);
    chk("R9 flag set", {31'd0, align_err}, 32'd1);
    repeat (5) @(negedge clk);
    chk("R9 flag sticky", {31'd0, align_err}, 32'd1);
    begin_prog();
    @(negedge clk);
    chk("R1 flag cleared by reset", {31'd0, align_err}, 32'd0);
    chk("R1 pc cleared by reset", imem_addr, 32'd0);
  endtask

  initial begin
    t_reset();
    t_alu_rr();
    t_alu_imm();
    t_zero_reg();
    t_ldst();
    t_branch();
    t_unknown();
    t_misalign();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule